// File: doc/BRIEF.md
# Coincident-Current Core Memory Cycle Controller

This block runs the read and write cycles of a word-organized magnetic core array built from one plane per data bit. A requester hands it an address, a read/write flag and write data through a valid/ready handshake. The block splits the address into an X index and a Y index. It then drives exactly one X select line and one Y select line, and that select is shared by every plane. Only the core where the two lines cross is addressed, and each plane returns one sense input.

Reading a core destroys its contents. Every access therefore begins by driving the addressed word toward the reference state, which is logic 0. A plane that reports a sense pulse held a 1, and a plane that stays quiet held a 0. One strobe cycle captures the sensed word. A restore phase then drives the word toward 1, and each plane whose target bit is 0 has its inhibit line raised so that its core stays at 0. On a read the target is the sensed word, so the data survives. On a write the target is the new data, so reads and writes share one cycle shape. Read data is returned once, when the restore has finished.

When the word count is set below the full X-by-Y size, an access to an address that has no core runs through the same cycle timing. It touches nothing in the array and returns zero.

Top module: `core_mem_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1. All X and Y select lines, `drive_pol`, `strobe`, `inhibit`, `rd_valid` and `rd_data` are 0.
- R2: At most one X line and at most one Y line are high in any cycle. For an access, X line `req_addr[X_BITS-1:0]` and Y line `req_addr[ADDR_W-1:X_BITS]` are driven from the cycle after acceptance through the end of restore.
- R3: For DRIVE_CYC cycles after acceptance (read drive), `drive_pol` is 0, meaning toward the reference state 0. `strobe` is 0 and all `inhibit` bits are 0.
- R4: In the single cycle after read drive, `strobe` is 1 with `drive_pol` 0. The `sense` bits are captured only in that cycle, and a sensed 1 means the core held 1.
- R5: For the DRIVE_CYC cycles after the strobe (restore), `drive_pol` is 1. `inhibit[i]` is 1 exactly when target bit i is 0. For a read the target is the captured word.
- R6: For a write (`req_we`=1), the restore target is `req_wdata`, and `rd_valid` stays 0 for the whole access.
- R7: For a read, `rd_valid` is 1 for exactly one cycle, 2*DRIVE_CYC+2 cycles after the accepting edge, with `rd_data` equal to the captured word. At all other times `rd_data` is 0.
- R8: `req_ready` is 0 from the cycle after acceptance until the end of the completion cycle. Request inputs presented while busy have no effect on the select lines or the data.
- R9: An address at or above WORDS drives no select line, no strobe, no drive polarity and no inhibit. It keeps the same cycle timing, and a read returns 0.
- R10: A read leaves the stored word unchanged, so reading the same address twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address, X index in the low bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | DATA_W | Read data, zero when not valid |
| x_sel | output | 2**X_BITS | One-hot X select lines |
| y_sel | output | 2**Y_BITS | One-hot Y select lines |
| drive_pol | output | 1 | Drive direction, 0 toward reference 0, 1 toward 1 |
| strobe | output | 1 | Sense sampling window |
| inhibit | output | DATA_W | Per-plane inhibit during restore |
| sense | input | DATA_W | Per-plane sense inputs |

## Verification
The bench targets several corner cases. The first is a word of all ones, where every plane pulses. A design that restored the wrong polarity, or captured sense outside the strobe, would lose it on the next read. Writes of all zeros and all ones exercise the extremes of inhibit, and a swapped inhibit sense would invert the stored word. Addresses at the highest X index and at the first Y step catch an address split with the index halves swapped. The last in-range word and two out-of-range words show whether the range gate leaks select activity or returns stale data. A request held at another address while the block is busy would show up as moving select lines if the handshake did not gate acceptance.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RDRV,
      PH_STRB,
      PH_RSTR,
      PH_DONE
   } phase_t;

endpackage

// File: rtl/core_addr_decode.sv
module core_addr_decode #(
   parameter int X_BITS = 6,
   parameter int Y_BITS = 6,
   parameter int WORDS  = 4000,
   localparam int ADDR_W = X_BITS + Y_BITS,
   localparam int NX     = 1 << X_BITS,
   localparam int NY     = 1 << Y_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              act,
   output logic [NX-1:0]     x_sel,
   output logic [NY-1:0]     y_sel,
   output logic              in_range
);

   localparam int FULL = NX * NY;

   logic [X_BITS-1:0] x_idx;
   logic [Y_BITS-1:0] y_idx;
   logic              fire;

   assign x_idx = addr[X_BITS-1:0];
   assign y_idx = addr[ADDR_W-1:X_BITS];

   // Range gate variant chosen by the word count
   generate
      if (WORDS >= FULL) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WORDS);
         assign in_range = ({1'b0, addr} < LIMIT);
      end
   endgenerate

   assign fire = act & in_range;

   genvar gx, gy;
   generate
      for (gx = 0; gx < NX; gx++) begin : g_x
         assign x_sel[gx] = fire & (x_idx == X_BITS'(gx));
      end
      for (gy = 0; gy < NY; gy++) begin : g_y
         assign y_sel[gy] = fire & (y_idx == Y_BITS'(gy));
      end
   endgenerate

endmodule

// File: rtl/core_phase_seq.sv
module core_phase_seq
   import core_mem_pkg::*;
#(
   parameter int DRIVE_CYC = 3,
   localparam int CNT_W = (DRIVE_CYC < 2) ? 1 : $clog2(DRIVE_CYC)
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DRIVE_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_RDRV;
            end
            PH_RDRV: begin
               if (cnt == LAST) begin
                  cnt   <= '0;
                  phase <= PH_STRB;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STRB: begin
               cnt   <= '0;
               phase <= PH_RSTR;
            end
            PH_RSTR: begin
               if (cnt == LAST) begin
                  cnt   <= '0;
                  phase <= PH_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               cnt   <= '0;
               phase <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/core_plane_slice.sv
module core_plane_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sample,
   input  logic sense_in,
   input  logic wr_mode,
   input  logic wr_bit,
   input  logic restore,
   output logic cap_bit,
   output logic inhibit_bit
);

   logic target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_bit <= 1'b0;
      else if (clear)  cap_bit <= 1'b0;
      else if (sample) cap_bit <= sense_in;
   end

   assign target      = wr_mode ? wr_bit : cap_bit;
   assign inhibit_bit = restore & ~target;

endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl
   import core_mem_pkg::*;
#(
   parameter int X_BITS    = 6,
   parameter int Y_BITS    = 6,
   parameter int DATA_W    = 16,
   parameter int WORDS     = 4000,
   parameter int DRIVE_CYC = 3,
   localparam int ADDR_W = X_BITS + Y_BITS,
   localparam int NX     = 1 << X_BITS,
   localparam int NY     = 1 << Y_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [NX-1:0]     x_sel,
   output logic [NY-1:0]     y_sel,
   output logic              drive_pol,
   output logic              strobe,
   output logic [DATA_W-1:0] inhibit,
   input  logic [DATA_W-1:0] sense
);

   generate
      if (X_BITS < 1 || Y_BITS < 1) begin : g_bad_dim
         $error("core_mem_ctrl: X_BITS and Y_BITS must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("core_mem_ctrl: DATA_W must be at least 1");
      end
      if (DRIVE_CYC < 1) begin : g_bad_drive
         $error("core_mem_ctrl: DRIVE_CYC must be at least 1");
      end
      if (WORDS < 1 || WORDS > NX * NY) begin : g_bad_words
         $error("core_mem_ctrl: WORDS must lie in 1 .. NX*NY");
      end
   endgenerate

   phase_t            phase;
   logic              accept;
   logic              driving;
   logic              in_range;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              we_q;
   logic [DATA_W-1:0] cap;
   logic [DATA_W-1:0] inh_raw;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         we_q    <= req_we;
      end
   end

   core_phase_seq #(
      .DRIVE_CYC(DRIVE_CYC)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .phase(phase)
   );

   assign driving = (phase == PH_RDRV) | (phase == PH_STRB) | (phase == PH_RSTR);

   core_addr_decode #(
      .X_BITS(X_BITS),
      .Y_BITS(Y_BITS),
      .WORDS (WORDS)
   ) u_dec (
      .addr    (addr_q),
      .act     (driving),
      .x_sel   (x_sel),
      .y_sel   (y_sel),
      .in_range(in_range)
   );

   genvar gp;
   generate
      for (gp = 0; gp < DATA_W; gp++) begin : g_plane
         core_plane_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (accept),
            .sample     ((phase == PH_STRB) & in_range),
            .sense_in   (sense[gp]),
            .wr_mode    (we_q),
            .wr_bit     (wdata_q[gp]),
            .restore    ((phase == PH_RSTR) & in_range),
            .cap_bit    (cap[gp]),
            .inhibit_bit(inh_raw[gp])
         );
      end
   endgenerate

   assign inhibit   = inh_raw;
   assign drive_pol = (phase == PH_RSTR) & in_range;
   assign strobe    = (phase == PH_STRB) & in_range;
   assign rd_valid  = (phase == PH_DONE) & ~we_q;
   assign rd_data   = rd_valid ? cap : '0;

endmodule

// File: rtl/core_mem_ctrl_chk.sv
module core_mem_ctrl_chk #(
   parameter int X_BITS = 6,
   parameter int Y_BITS = 6,
   parameter int DATA_W = 16,
   localparam int ADDR_W = X_BITS + Y_BITS,
   localparam int NX     = 1 << X_BITS,
   localparam int NY     = 1 << Y_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_we,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic [NX-1:0]     x_sel,
   input logic [NY-1:0]     y_sel,
   input logic              drive_pol,
   input logic              strobe,
   input logic [DATA_W-1:0] inhibit,
   input logic [DATA_W-1:0] sense
);

   a_r2_x_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(x_sel));

   a_r2_y_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(y_sel));

   a_r2_xy_paired: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(x_sel) == $countones(y_sel)));

   a_r4_strobe_dir: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (!drive_pol && (x_sel != '0)));

   a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   a_r5_inhibit_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit != '0) |-> drive_pol);

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> (!rd_valid && req_ready));

   a_r7_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (x_sel == '0) |-> (!strobe && !drive_pol && inhibit == '0));

endmodule

bind core_mem_ctrl core_mem_ctrl_chk #(
   .X_BITS(X_BITS),
   .Y_BITS(Y_BITS),
   .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/core_mem_ctrl_tb_top.sv
module core_mem_ctrl_tb_top;

   localparam int XB = 6;
   localparam int YB = 6;
   localparam int DW = 16;
   localparam int WD = 4000;
   localparam int DC = 3;
   localparam int AW = XB + YB;
   localparam int NX = 1 << XB;
   localparam int NY = 1 << YB;
   localparam int NW = NX * NY;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [NX-1:0] x_sel;
   logic [NY-1:0] y_sel;
   logic          drive_pol;
   logic          strobe;
   logic [DW-1:0] inhibit;
   logic [DW-1:0] sense;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   core_mem_ctrl #(
      .X_BITS(XB), .Y_BITS(YB), .DATA_W(DW), .WORDS(WD), .DRIVE_CYC(DC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .x_sel(x_sel), .y_sel(y_sel),
      .drive_pol(drive_pol), .strobe(strobe), .inhibit(inhibit), .sense(sense)
   );

   // Behavioural core array: one word per crossing, one plane per bit
   logic [DW-1:0] arr [NW];
   logic [DW-1:0] exp_mem [NW];
   logic [DW-1:0] held = '0;
   int            mx, my;
   logic          selok;

   always_comb begin
      mx = 0;
      my = 0;
      for (int i = 0; i < NX; i++) if (x_sel[i]) mx = i;
      for (int j = 0; j < NY; j++) if (y_sel[j]) my = j;
      selok = $onehot(x_sel) && $onehot(y_sel);
      sense = (strobe && selok) ? held : '0;
   end

   always @(posedge clk) begin
      if (selok) begin
         if (!drive_pol) begin
            if (arr[my*NX+mx] != '0) begin
               held <= arr[my*NX+mx];
               arr[my*NX+mx] <= '0;
            end
         end else begin
            arr[my*NX+mx] <= arr[my*NX+mx] | ~inhibit;
            held <= '0;
         end
      end
   end

   always @(posedge clk) cycles <= cycles + 1;

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input bit we, input int a, input logic [DW-1:0] d);
      logic [DW-1:0] old, tgt;
      bit            inr;
      inr = (a < WD);
      old = inr ? exp_mem[a] : '0;
      tgt = we ? d : old;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = AW'(a);
      req_wdata = d;
      @(negedge clk);
      // R8: keep offering a different request while busy
      req_addr  = AW'(a ^ 1);
      req_wdata = ~d;
      req_we    = ~we;
      for (int k = 1; k <= 2*DC+2; k++) begin
         logic [NX-1:0] ex;
         logic [NY-1:0] ey;
         bit            drv, rst_ph, stb;
         string         rq;
         drv    = (k <= 2*DC+1);
         stb    = (k == DC+1);
         rst_ph = (k >= DC+2) && (k <= 2*DC+1);
         ex = (drv && inr) ? (NX'(1) << (a % NX)) : '0;
         ey = (drv && inr) ? (NY'(1) << (a / NX)) : '0;
         rq = !inr ? "R9" : (k <= DC) ? "R3" : stb ? "R4" :
              rst_ph ? (we ? "R6" : "R5") : (we ? "R6" : "R7");
         chk(x_sel == ex && y_sel == ey, rq, "R2 select lines",
             {x_sel, y_sel}, {ex, ey});
         chk(drive_pol == (rst_ph && inr) && strobe == (stb && inr), rq,
             "drive_pol/strobe", {drive_pol, strobe}, {rst_ph && inr, stb && inr});
         chk(inhibit == ((rst_ph && inr) ? ~tgt : '0), rq, "inhibit",
             inhibit, (rst_ph && inr) ? ~tgt : '0);
         chk(req_ready == 1'b0, "R8", "ready while busy", req_ready, 1'b0);
         chk(rd_valid == (k == 2*DC+2 && !we), rq, "rd_valid timing",
             rd_valid, (k == 2*DC+2 && !we));
         chk(rd_data == ((k == 2*DC+2 && !we) ? old : '0), rq, "rd_data",
             rd_data, (k == 2*DC+2 && !we) ? old : '0);
         if (k == 2*DC+2) req_valid = 1'b0;
         @(negedge clk);
      end
      chk(req_ready == 1'b1, "R8", "ready after completion", req_ready, 1'b1);
      if (inr) exp_mem[a] = tgt;
   endtask

   initial begin
      for (int i = 0; i < NW; i++) begin
         arr[i]     = DW'(i * 40503) ^ 16'h5A3C;
         exp_mem[i] = DW'(i * 40503) ^ 16'h5A3C;
      end
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1 && x_sel == '0 && y_sel == '0, "R1", "ready/selects",
          {req_ready, x_sel, y_sel}, {1'b1, 128'h0});
      chk(!drive_pol && !strobe && inhibit == '0 && !rd_valid && rd_data == '0,
          "R1", "array outputs", {drive_pol, strobe, inhibit, rd_valid, rd_data},
          '0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(1'b0, 5, '0);            // R7 plain read
      run_op(1'b0, 5, '0);            // R10 second read same value
      run_op(1'b1, 100, 16'h0000);    // R6 all inhibit
      run_op(1'b0, 100, '0);
      run_op(1'b1, 100, 16'hFFFF);    // R6 no inhibit
      run_op(1'b0, 100, '0);          // R4 every plane pulses
      run_op(1'b0, 100, '0);          // R10
      run_op(1'b1, 63, 16'hA5C3);     // R2 highest X index
      run_op(1'b1, 64, 16'h3C5A);     // R2 first Y step
      run_op(1'b0, 63, '0);
      run_op(1'b0, 64, '0);
      run_op(1'b0, WD - 1, '0);       // R9 last valid word
      run_op(1'b0, WD, '0);           // R9 first missing word
      run_op(1'b1, NW - 1, 16'h1234); // R9 write with no effect
      run_op(1'b0, NW - 1, '0);
      run_op(1'b0, 0, '0);

      // R10: the whole array matches the expected contents
      begin
         int bad = 0;
         for (int i = 0; i < NW; i++) if (arr[i] !== exp_mem[i]) bad++;
         chk(bad == 0, "R10", "array words differing", 128'(bad), 128'h0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule